// File: doc/BRIEF.md
# OUT Endpoint DMA Channel

This block drains received OUT-endpoint packet bytes from a bank manager and writes them, one byte per handshake, to consecutive memory addresses through a valid/ready write port. Software starts a transfer with a single load pulse that carries the destination address, the buffer length in bytes and a set of control bits. While the channel runs, the address moves up by one and the remaining count moves down by one for every byte the memory side accepts.

A transfer ends in one of three ways. The remaining count can reach zero. The last byte of a short packet can arrive while early stop is enabled. A zero-length packet can arrive while early stop is enabled. When the buffer fills in the middle of a packet, the bytes that are left either stay in the bank or are popped and dropped, depending on the truncation bit. Every packet whose final byte leaves the bank, and every zero-length packet that is consumed, produces a release pulse that hands the bank back to the bank manager. Two sticky end-cause bits record why a transfer stopped. Software clears them by writing ones, and an interrupt output combines each cause with its enable.

Top module: `ochan_dma`

## Requirements
- R1: After reset, st_busy, st_cause, irq, wr_valid, bk_ready and bk_release are all 0, and st_addr and st_count are 0.
- R2: A cfg_load pulse with cfg_run=1 and a nonzero cfg_len sets st_busy and loads st_addr and st_count from cfg_addr and cfg_len on the next clock. A cfg_load pulse with cfg_run=0 makes st_busy 0 and leaves the programmed address and count visible.
- R3: While the channel is busy and the bank offers a data byte, wr_valid is 1, wr_addr equals st_addr and wr_data equals bk_data. bk_ready equals wr_ready. Each accepted byte adds 1 to st_addr and subtracts 1 from st_count.
- R4: When the byte that brings st_count to 0 is written, cause bit 0 (buffer end) is set and the channel stops. If truncation is off, any remaining bytes of that packet stay in the bank (bk_ready stays 0).
- R5: With cfg_trunc=1, when the count reaches 0 before a packet's last byte, the rest of that packet is popped (bk_ready=1) without any write (wr_valid=0). The channel stops after the packet's last byte.
- R6: With cfg_eot_stop=1, writing the last byte of a short packet (bk_last=1 and bk_short=1) sets cause bit 1 (end of transfer) and stops the channel with the count left as it is. With cfg_eot_stop=0, a short packet does not stop the channel.
- R7: A zero-length packet (bk_valid=1, bk_zlp=1) offered while the channel is busy is popped with no write. With cfg_eot_stop=1 it sets cause bit 1 and stops the channel. With cfg_eot_stop=0 the channel keeps running with the count unchanged.
- R8: bk_release pulses for one cycle in exactly the cycles in which a byte with bk_last=1 or a zero-length packet is popped, whether the byte is written or dropped.
- R9: A 1 in bit i of cause_clr clears st_cause[i]. A cause that is being set in the same cycle stays set. Otherwise a cause bit holds its value.
- R10: irq is 1 exactly when (st_cause[0] and cfg_buf_irq) or (st_cause[1] and cfg_eot_irq) holds, with the enables taken from the last load.
- R11: A cfg_load with cfg_run=1 and cfg_len=0 sets cause bit 0 on the next clock, performs no transfer and leaves st_busy at 0.
- R12: While the channel is idle, and in any cycle with cfg_load=1, wr_valid and bk_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load pulse for address, length and control bits |
| cfg_run | input | 1 | Start the channel on this load (0 stops it) |
| cfg_trunc | input | 1 | Drop the rest of a packet when the buffer fills |
| cfg_eot_stop | input | 1 | A short or zero-length packet ends the transfer |
| cfg_eot_irq | input | 1 | Interrupt enable for the end-of-transfer cause |
| cfg_buf_irq | input | 1 | Interrupt enable for the buffer-end cause |
| cfg_addr | input | ADDR_W | Destination start address |
| cfg_len | input | LEN_W | Buffer length in bytes |
| cause_clr | input | 2 | Write-one-to-clear strobes for the cause bits |
| bk_valid | input | 1 | Bank offers a byte or a zero-length marker |
| bk_data | input | DATA_W | Byte from the bank |
| bk_last | input | 1 | Offered byte is the last of its packet |
| bk_short | input | 1 | Offered packet is shorter than max size |
| bk_zlp | input | 1 | Offer is a zero-length packet, no data |
| bk_ready | output | 1 | Pop of the offered item |
| bk_release | output | 1 | Bank drained and handed back |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Memory write data |
| wr_ready | input | 1 | Memory accepts the write |
| st_addr | output | ADDR_W | Current address |
| st_count | output | LEN_W | Remaining byte count |
| st_busy | output | 1 | Channel running or dropping |
| st_cause | output | 2 | Sticky causes: bit 0 buffer end, bit 1 end of transfer |
| irq | output | 1 | Interrupt request |

## Verification
A wrong address or count register shows at the ports on the next accepted byte, through wr_addr and st_count, and the per-clock comparison against the bench model catches it at that edge. A wrong stop decision, such as a missed end of transfer or a drop that continues past the packet end, shows up within one clock as a mismatch in st_busy or bk_ready. The bank queue in the bench then holds more or fewer bytes than the scenario expects. A wrong cause or enable latch appears on st_cause and irq in the cycle after the ending byte.

// File: rtl/ochan_dma_pkg.sv
package ochan_dma_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_RUN   = 2'd1,
      CH_DRAIN = 2'd2
   } ch_state_e;

   localparam int unsigned N_CAUSE   = 2;
   localparam int unsigned CAUSE_BUF = 0;
   localparam int unsigned CAUSE_EOT = 1;

   typedef struct packed {
      logic trunc_en;
      logic eot_stop;
      logic eot_irq;
      logic buf_irq;
   } ch_ctrl_t;

endpackage

// File: rtl/ochan_dma_ptr.sv
module ochan_dma_ptr #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LEN_W-1:0]  ld_len,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  count,
   output logic              last_unit
);

   localparam logic [LEN_W-1:0]  ONE_LEN  = LEN_W'(1);
   localparam logic [ADDR_W-1:0] ONE_ADDR = ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         count <= '0;
      end else if (load) begin
         addr  <= ld_addr;
         count <= ld_len;
      end else if (step) begin
         addr  <= addr + ONE_ADDR;
         count <= count - ONE_LEN;
      end
   end

   assign last_unit = (count == ONE_LEN);

   // R4: a byte is never taken once the buffer is exhausted
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (count != '0));

   // R3: an accepted byte moves the address by one
   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr == $past(addr) + ONE_ADDR));

endmodule

// File: rtl/ochan_dma_seq.sv
module ochan_dma_seq
   import ochan_dma_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_load,
   input  logic     cfg_run,
   input  ch_ctrl_t cfg_ctrl,
   input  logic     len_zero,
   input  logic     last_unit,
   input  logic     bk_valid,
   input  logic     bk_last,
   input  logic     bk_short,
   input  logic     bk_zlp,
   input  logic     wr_ready,
   output logic     wr_valid,
   output logic     bk_ready,
   output logic     bk_release,
   output logic     step,
   output logic     set_buf,
   output logic     set_eot,
   output logic     busy,
   output ch_ctrl_t ctrl_q
);

   ch_state_e state_q, state_d;
   logic act, in_run, in_drain, data_byte, wr_fire, zlp_take, drop;
   logic hit_end, short_end, zlp_end;

   assign act       = !cfg_load;
   assign in_run    = act && (state_q == CH_RUN);
   assign in_drain  = act && (state_q == CH_DRAIN);
   assign data_byte = bk_valid && !bk_zlp;

   assign wr_valid  = in_run && data_byte;
   assign wr_fire   = wr_valid && wr_ready;
   assign zlp_take  = in_run && bk_valid && bk_zlp;
   assign drop      = in_drain && data_byte;

   assign bk_ready   = (in_run && ((data_byte && wr_ready) || (bk_valid && bk_zlp))) || drop;
   assign bk_release = ((wr_fire || drop) && bk_last) || zlp_take;
   assign step       = wr_fire;

   assign hit_end   = wr_fire && last_unit;
   assign short_end = wr_fire && bk_last && bk_short && ctrl_q.eot_stop;
   assign zlp_end   = zlp_take && ctrl_q.eot_stop;

   assign set_buf = cfg_load ? (cfg_run && len_zero) : hit_end;
   assign set_eot = short_end || zlp_end;
   assign busy    = (state_q != CH_IDLE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         CH_RUN: begin
            if (hit_end && !bk_last && ctrl_q.trunc_en) begin
               state_d = CH_DRAIN;
            end else if (hit_end || short_end || zlp_end) begin
               state_d = CH_IDLE;
            end
         end
         CH_DRAIN: begin
            if (drop && bk_last) begin
               state_d = CH_IDLE;
            end
         end
         default: state_d = state_q;
      endcase
      if (cfg_load) begin
         state_d = (cfg_run && !len_zero) ? CH_RUN : CH_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         ctrl_q  <= '0;
      end else begin
         state_q <= state_d;
         if (cfg_load) begin
            ctrl_q <= cfg_ctrl;
         end
      end
   end

   // R12: an idle channel neither writes nor pops
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_IDLE) |-> (!wr_valid && !bk_ready));

   // R5: the drop phase never issues a write
   p_drain_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_DRAIN) |-> !wr_valid);

   // R3: an accepted write always pops exactly the offered byte
   p_write_pops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |-> bk_ready);

   // R6: after an early stop the channel is idle
   p_eot_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_eot && !cfg_load) |=> (state_q == CH_IDLE));

endmodule

// File: rtl/ochan_dma_cause.sv
module ochan_dma_cause
   import ochan_dma_pkg::*;
#(
   parameter int unsigned IRQ_REG = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CAUSE-1:0] set,
   input  logic [N_CAUSE-1:0] clr,
   input  logic [N_CAUSE-1:0] en,
   output logic [N_CAUSE-1:0] cause,
   output logic               irq
);

   logic [N_CAUSE-1:0] cause_q;
   logic               irq_d;

   for (genvar i = 0; i < N_CAUSE; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cause_q[i] <= 1'b0;
         end else if (set[i]) begin
            cause_q[i] <= 1'b1;
         end else if (clr[i]) begin
            cause_q[i] <= 1'b0;
         end
      end

      // R9: a cause holds unless cleared
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (cause_q[i] && !clr[i]) |=> cause_q[i]);

      // R9: setting wins over a simultaneous clear
      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> cause_q[i]);
   end

   assign cause = cause_q;
   assign irq_d = |(cause_q & en);

   if (IRQ_REG != 0) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= irq_d;
         end
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_d;
   end

endmodule

// File: rtl/ochan_dma.sv
module ochan_dma
   import ochan_dma_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LEN_W   = 12,
   parameter int unsigned IRQ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic              cfg_run,
   input  logic              cfg_trunc,
   input  logic              cfg_eot_stop,
   input  logic              cfg_eot_irq,
   input  logic              cfg_buf_irq,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [1:0]        cause_clr,
   input  logic              bk_valid,
   input  logic [DATA_W-1:0] bk_data,
   input  logic              bk_last,
   input  logic              bk_short,
   input  logic              bk_zlp,
   output logic              bk_ready,
   output logic              bk_release,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] st_addr,
   output logic [LEN_W-1:0]  st_count,
   output logic              st_busy,
   output logic [1:0]        st_cause,
   output logic              irq
);

   if (DATA_W < 1 || ADDR_W < 2 || LEN_W < 2) begin : g_bad_width
      $error("ochan_dma: DATA_W>=1, ADDR_W>=2 and LEN_W>=2 are required");
   end
   if (IRQ_REG > 1) begin : g_bad_irq
      $error("ochan_dma: IRQ_REG must be 0 or 1");
   end

   ch_ctrl_t           cfg_ctrl, ctrl_q;
   logic               len_zero, last_unit, step, set_buf, set_eot;
   logic [N_CAUSE-1:0] cause_set, cause_en;

   assign cfg_ctrl = '{trunc_en: cfg_trunc, eot_stop: cfg_eot_stop,
                       eot_irq: cfg_eot_irq, buf_irq: cfg_buf_irq};
   assign len_zero = (cfg_len == '0);

   ochan_dma_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_load),
      .ld_addr   (cfg_addr),
      .ld_len    (cfg_len),
      .step      (step),
      .addr      (st_addr),
      .count     (st_count),
      .last_unit (last_unit)
   );

   ochan_dma_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_load   (cfg_load),
      .cfg_run    (cfg_run),
      .cfg_ctrl   (cfg_ctrl),
      .len_zero   (len_zero),
      .last_unit  (last_unit),
      .bk_valid   (bk_valid),
      .bk_last    (bk_last),
      .bk_short   (bk_short),
      .bk_zlp     (bk_zlp),
      .wr_ready   (wr_ready),
      .wr_valid   (wr_valid),
      .bk_ready   (bk_ready),
      .bk_release (bk_release),
      .step       (step),
      .set_buf    (set_buf),
      .set_eot    (set_eot),
      .busy       (st_busy),
      .ctrl_q     (ctrl_q)
   );

   assign cause_set[CAUSE_BUF] = set_buf;
   assign cause_set[CAUSE_EOT] = set_eot;
   assign cause_en[CAUSE_BUF]  = ctrl_q.buf_irq;
   assign cause_en[CAUSE_EOT]  = ctrl_q.eot_irq;

   ochan_dma_cause #(.IRQ_REG(IRQ_REG)) u_cause (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (cause_set),
      .clr   (cause_clr),
      .en    (cause_en),
      .cause (st_cause),
      .irq   (irq)
   );

   assign wr_addr = st_addr;
   assign wr_data = bk_data;

   // R8: a release only accompanies a real pop
   p_release_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bk_release |-> (bk_ready && bk_valid));

   // R11: a zero-length load never starts the channel
   p_zero_len_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load && cfg_run && len_zero) |=> !st_busy);

endmodule

// File: tb/ochan_dma_tb.sv
module ochan_dma_tb;

   localparam int DW = 8;
   localparam int AW = 16;
   localparam int LW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 0, cfg_run = 0, cfg_trunc = 0, cfg_eot_stop = 0;
   logic cfg_eot_irq = 0, cfg_buf_irq = 0;
   logic [AW-1:0] cfg_addr = '0;
   logic [LW-1:0] cfg_len = '0;
   logic [1:0] cause_clr = '0;
   logic bk_valid = 0, bk_last = 0, bk_short = 0, bk_zlp = 0;
   logic [DW-1:0] bk_data = '0;
   logic wr_ready = 0;
   logic bk_ready, bk_release, wr_valid, st_busy, irq;
   logic [AW-1:0] wr_addr, st_addr;
   logic [DW-1:0] wr_data;
   logic [LW-1:0] st_count;
   logic [1:0] st_cause;

   always #10 clk = ~clk;

   ochan_dma #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_run(cfg_run),
      .cfg_trunc(cfg_trunc), .cfg_eot_stop(cfg_eot_stop), .cfg_eot_irq(cfg_eot_irq),
      .cfg_buf_irq(cfg_buf_irq), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
      .cause_clr(cause_clr), .bk_valid(bk_valid), .bk_data(bk_data),
      .bk_last(bk_last), .bk_short(bk_short), .bk_zlp(bk_zlp), .bk_ready(bk_ready),
      .bk_release(bk_release), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_ready(wr_ready), .st_addr(st_addr),
      .st_count(st_count), .st_busy(st_busy), .st_cause(st_cause), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int cyc_n = 0;

   // bank contents: one entry per byte or zero-length marker
   int q_d[$];
   bit q_l[$], q_s[$], q_z[$];

   // reference model state
   int m_mode = 0;   // 0 idle, 1 running, 2 dropping
   int m_addr = 0, m_cnt = 0;
   bit m_trunc = 0, m_eot = 0, m_ieot = 0, m_ibuf = 0;
   bit m_cb = 0, m_ce = 0;
   logic [7:0] lfsr = 8'hA5;

   bit e_wv, e_rdy, e_rel;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cyc_n);
      end
   endtask

   function automatic void exp_comb();
      bit act, dbyte;
      act   = !cfg_load;
      dbyte = bk_valid && !bk_zlp;
      e_wv  = act && m_mode == 1 && dbyte;
      e_rdy = act && ((m_mode == 1 && ((dbyte && wr_ready) || (bk_valid && bk_zlp)))
                      || (m_mode == 2 && dbyte));
      e_rel = e_rdy && bk_valid && (bk_last || bk_zlp);
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit sb, se, fire;
         cyc_n++;
         exp_comb();
         sb = 0; se = 0;
         fire = e_wv && wr_ready;
         if (cfg_load) begin
            m_addr = int'(cfg_addr); m_cnt = int'(cfg_len);
            m_trunc = cfg_trunc; m_eot = cfg_eot_stop;
            m_ieot = cfg_eot_irq; m_ibuf = cfg_buf_irq;
            m_mode = (cfg_run && cfg_len != 0) ? 1 : 0;
            sb = cfg_run && cfg_len == 0;
         end else if (m_mode == 1) begin
            if (fire) begin
               m_addr = (m_addr + 1) % (1 << AW);
               m_cnt  = m_cnt - 1;
               if (m_cnt == 0) sb = 1;
               if (bk_last && bk_short && m_eot) se = 1;
               if (sb && !bk_last && m_trunc) m_mode = 2;
               else if (sb || se) m_mode = 0;
            end else if (e_rdy && bk_zlp && m_eot) begin
               se = 1; m_mode = 0;
            end
         end else if (m_mode == 2) begin
            if (e_rdy && bk_last) m_mode = 0;
         end
         m_cb = sb || (m_cb && !cause_clr[0]);
         m_ce = se || (m_ce && !cause_clr[1]);
         if (e_rdy && bk_valid) begin
            void'(q_d.pop_front()); void'(q_l.pop_front());
            void'(q_s.pop_front()); void'(q_z.pop_front());
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
   end

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      if (q_d.size() > 0) begin
         bk_valid = 1; bk_data = q_d[0][DW-1:0]; bk_last = q_l[0];
         bk_short = q_s[0]; bk_zlp = q_z[0];
      end else begin
         bk_valid = 0; bk_data = '0; bk_last = 0; bk_short = 0; bk_zlp = 0;
      end
      wr_ready = lfsr[0] | lfsr[1];
      #1;
      exp_comb();
      chk("R3 wr_valid", wr_valid, e_wv);
      chk(m_mode == 0 ? "R12 bk_ready" : "R3 bk_ready", bk_ready, e_rdy);
      chk("R8 bk_release", bk_release, e_rel);
      chk("R2 st_busy", st_busy, m_mode != 0);
      chk("R3 st_addr", st_addr, m_addr);
      chk("R4 st_count", st_count, m_cnt);
      chk("R9 st_cause", st_cause, {m_ce, m_cb});
      chk("R10 irq", irq, (m_ce && m_ieot) || (m_cb && m_ibuf));
      if (e_wv) begin
         chk("R3 wr_addr", wr_addr, m_addr);
         chk("R3 wr_data", wr_data, bk_data);
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic do_load(input int a, input int len, input bit run_b, input bit tr,
                          input bit eo, input bit ie, input bit ib);
      cfg_addr = AW'(a); cfg_len = LW'(len); cfg_run = run_b; cfg_trunc = tr;
      cfg_eot_stop = eo; cfg_eot_irq = ie; cfg_buf_irq = ib; cfg_load = 1;
      cyc();
      cfg_load = 0;
   endtask

   task automatic clear_all();
      cause_clr = 2'b11;
      cyc();
      cause_clr = 2'b00;
   endtask

   task automatic push_pkt(input int n, input bit sh, input int base);
      for (int i = 0; i < n; i++) begin
         q_d.push_back((base + i) & 8'hFF); q_l.push_back(i == n - 1);
         q_s.push_back(sh); q_z.push_back(0);
      end
   endtask

   task automatic push_zlp();
      q_d.push_back(0); q_l.push_back(1); q_s.push_back(1); q_z.push_back(1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      #5;
      chk("R1 reset busy", st_busy, 0);
      chk("R1 reset cause", st_cause, 0);
      chk("R1 reset irq", irq, 0);
      chk("R1 reset wr_valid", wr_valid, 0);
      chk("R1 reset addr", st_addr, 0);
      chk("R1 reset count", st_count, 0);
      run(2);
      rst_n = 1;
      run(2);

      // R6: short packet ends early with eot stop
      do_load(16'h0100, 6, 1, 0, 1, 1, 1);
      chk("R2 loaded busy", st_busy, 1);
      chk("R2 loaded addr", st_addr, 16'h0100);
      chk("R2 loaded count", st_count, 6);
      push_pkt(4, 1, 8'h10);
      run(30);
      chk("R6 short stop busy", st_busy, 0);
      chk("R6 short stop count", st_count, 2);
      chk("R6 short stop addr", st_addr, 16'h0104);
      chk("R6 short stop cause", st_cause, 2'b10);
      chk("R10 eot irq", irq, 1);
      cause_clr = 2'b10; cyc(); cause_clr = 2'b00;
      chk("R9 w1c cause", st_cause, 2'b00);
      chk("R10 irq cleared", irq, 0);

      // R4: buffer fills, leftovers stay in the bank
      do_load(16'h0200, 3, 1, 0, 0, 0, 1);
      push_pkt(5, 0, 8'h20);
      run(30);
      chk("R4 bufend busy", st_busy, 0);
      chk("R4 bufend count", st_count, 0);
      chk("R4 bufend addr", st_addr, 16'h0203);
      chk("R4 bufend cause", st_cause, 2'b01);
      chk("R4 leftover kept", q_d.size(), 2);
      chk("R4 no pop after end", bk_ready, 0);
      clear_all();
      do_load(16'h0210, 2, 1, 0, 0, 0, 1);
      run(20);
      chk("R8 leftover drained", q_d.size(), 0);
      chk("R3 second addr", st_addr, 16'h0212);

      // R5: truncation drops the rest of the packet
      clear_all();
      do_load(16'h0300, 2, 1, 1, 0, 0, 0);
      push_pkt(5, 0, 8'h30);
      run(30);
      chk("R5 trunc bank empty", q_d.size(), 0);
      chk("R5 trunc addr", st_addr, 16'h0302);
      chk("R5 trunc busy", st_busy, 0);
      chk("R5 trunc cause", st_cause, 2'b01);
      chk("R10 masked irq", irq, 0);

      // R7: zero-length packet with eot stop
      clear_all();
      do_load(16'h0400, 10, 1, 0, 1, 1, 0);
      push_zlp();
      run(10);
      chk("R7 zlp consumed", q_d.size(), 0);
      chk("R7 zlp count", st_count, 10);
      chk("R7 zlp cause", st_cause, 2'b10);
      chk("R7 zlp busy", st_busy, 0);

      // R6 and R7 with eot stop disabled: channel keeps running
      clear_all();
      do_load(16'h0500, 4, 1, 0, 0, 0, 0);
      push_zlp();
      push_pkt(2, 1, 8'h50);
      run(20);
      chk("R7 zlp no stop busy", st_busy, 1);
      chk("R6 short no stop count", st_count, 2);
      chk("R6 short no stop cause", st_cause, 2'b00);
      push_pkt(2, 0, 8'h60);
      run(20);
      chk("R4 final count", st_count, 0);
      chk("R4 final addr", st_addr, 16'h0504);
      chk("R4 final cause", st_cause, 2'b01);

      // R11: zero-length buffer
      clear_all();
      do_load(16'h0600, 0, 1, 0, 0, 0, 1);
      chk("R11 zero len busy", st_busy, 0);
      chk("R11 zero len cause", st_cause, 2'b01);
      chk("R11 zero len irq", irq, 1);

      // R2: stop by a load with run cleared
      clear_all();
      do_load(16'h0700, 8, 1, 0, 0, 0, 0);
      run(2);
      chk("R2 running", st_busy, 1);
      do_load(16'h0700, 8, 0, 0, 0, 0, 0);
      chk("R2 stopped", st_busy, 0);
      chk("R2 stopped count", st_count, 8);
      push_pkt(3, 0, 8'h70);
      run(5);
      chk("R12 idle no pop", q_d.size(), 3);

      finish_run();
   end

endmodule